// File: doc/BRIEF.md
# Line-Locked Chroma Phase Generator

This block produces the timing for a digitally synthesised colour subcarrier. It runs on a fast clock that is a fixed multiple of the subcarrier frequency and keeps a phase counter that subdivides each subcarrier period into fast-clock steps. The counter is forced to zero when a horizontal sync pulse ends. Colour phase therefore depends only on line timing, and no burst or free-running subcarrier oscillator is used.

The DAC is still loaded at four times the subcarrier frequency. Each load strobe falls a programmable number of fast-clock steps after the restarted phase origin, so the output can be trimmed in sub-sample steps until the hues are correct. With each strobe the block gives a phase index that selects one of sixteen chroma sample phases. A colour index is added to this value, so each colour is a rotation of the base phase. Short spikes on the sync input are rejected and do not restart the phase.

Top module: `chroma_phase_gen`

## Requirements
- R1: While rst_ni is low, strobe_o and phase_o are 0. After the first rising edge following reset release, the outputs reflect a phase count of 0, and the count then advances by one per edge.
- R2: hsync_i is active high and passes through a two-stage synchroniser. Let E0 be the first rising edge that samples hsync_i low after a qualifying high run. The phase count is 0 after edge E2, and the outputs after edge E3+j reflect count j.
- R3: A high run on hsync_i counts only if it lasts at least MIN_HS_CYCLES (default 8) consecutive sampled clock cycles. A shorter run, including exactly MIN_HS_CYCLES-1, causes no restart, and the count keeps running.
- R4: Without a restart, the phase count increases by one on each clock and wraps from SC_DIV-1 (default 63) to 0.
- R5: Define rel = (count - offset_i) mod SC_DIV. strobe_o is registered and is high for one cycle exactly when rel mod (SC_DIV/DAC_PER_SC) is 0. With the defaults this gives 4 strobes per 64-step subcarrier period, delayed by offset_i fast cycles.
- R6: phase_o is registered every cycle as ((rel >> log2(SC_DIV/PH_N)) + colour_i) mod PH_N. With the defaults this is rel/4 plus colour_i modulo 16, so a strobe always carries a multiple of 4 plus colour_i.
- R7: offset_i is a 6-bit trim whose full range 0 to 63 is legal. An offset of 63 places the strobes one step before offset 0 would.
- R8: colour_i (4 bits) wraps modulo 16. For example, base phase 12 with colour_i = 15 gives phase_o = 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, SC_DIV times the subcarrier |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, asynchronous |
| offset_i | input | 6 | Strobe delay in fast-clock steps within one subcarrier period |
| colour_i | input | 4 | Colour phase rotation added to the base phase |
| strobe_o | output | 1 | DAC load strobe, one cycle wide |
| phase_o | output | 4 | Chroma sample phase index |

## Verification
The case that is hardest to reach from the ports is a sync high run whose length sits exactly at the qualification threshold. The run must end while the counter is partway through a period and the offset is not zero, so that a restart and a missed restart give different strobe positions. The stimulus holds hsync_i high for exactly MIN_HS_CYCLES and then for exactly one cycle less, each time from a known count. It then sends random lines whose high runs are drawn from both sides of the threshold, with a fresh offset and colour on each line. The bench follows the expected count through every sampled edge and compares strobe_o and phase_o on every cycle.

// File: rtl/chroma_pkg.sv
package chroma_pkg;
  localparam int unsigned SC_DIV_DEF  = 64;  // fast clocks per subcarrier period
  localparam int unsigned DAC_PER_SC  = 4;   // DAC loads per subcarrier period
  localparam int unsigned PH_N_DEF    = 16;  // distinct chroma phases
  localparam int unsigned MIN_HS_DEF  = 8;   // minimum qualifying sync width
endpackage

// File: rtl/chroma_hs_qual.sv
module chroma_hs_qual #(
  parameter int unsigned MIN_HS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic restart_o
);
  localparam int unsigned HC_W = $clog2(MIN_HS + 1);
  localparam logic [HC_W-1:0] HC_MAX = HC_W'(MIN_HS);

  logic            sync1_q, sync2_q;
  logic [HC_W-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q  <= 1'b0;
      sync2_q  <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      sync1_q <= hsync_i;
      sync2_q <= sync1_q;
      if (!sync2_q)             hi_cnt_q <= '0;
      else if (hi_cnt_q != HC_MAX) hi_cnt_q <= hi_cnt_q + 1'b1;
    end
  end

  // trailing edge of a run that reached the minimum width
  assign restart_o = !sync2_q && (hi_cnt_q == HC_MAX);
endmodule

// File: rtl/chroma_phase_cnt.sv
module chroma_phase_cnt #(
  parameter int unsigned SC_DIV = 64,
  localparam int unsigned CNT_W = $clog2(SC_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SC_DIV - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_o <= '0;
    else if (restart_i)        cnt_o <= '0;
    else if (cnt_o == CNT_TOP) cnt_o <= '0;
    else                       cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/chroma_strobe_gen.sv
module chroma_strobe_gen #(
  parameter int unsigned SC_DIV = 64,
  parameter int unsigned DAC_N  = 4,
  parameter int unsigned PH_N   = 16,
  localparam int unsigned CNT_W  = $clog2(SC_DIV),
  localparam int unsigned PH_W   = $clog2(PH_N),
  localparam int unsigned SLOT_W = $clog2(SC_DIV / DAC_N),
  localparam int unsigned SHIFT  = CNT_W - PH_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [PH_W-1:0]  colour_i,
  output logic             strobe_o,
  output logic [PH_W-1:0]  phase_o
);
  logic [CNT_W-1:0] rel;
  assign rel = cnt_i - offset_i;  // power-of-two modulus wraps naturally

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      phase_o  <= '0;
    end else begin
      strobe_o <= (rel[SLOT_W-1:0] == '0);
      phase_o  <= rel[CNT_W-1:SHIFT] + colour_i;
    end
  end
endmodule

// File: rtl/chroma_phase_gen.sv
module chroma_phase_gen #(
  parameter int unsigned SC_DIV = chroma_pkg::SC_DIV_DEF,
  parameter int unsigned DAC_N  = chroma_pkg::DAC_PER_SC,
  parameter int unsigned PH_N   = chroma_pkg::PH_N_DEF,
  parameter int unsigned MIN_HS = chroma_pkg::MIN_HS_DEF,
  localparam int unsigned CNT_W = $clog2(SC_DIV),
  localparam int unsigned PH_W  = $clog2(PH_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic [CNT_W-1:0] offset_i,
  input  logic [PH_W-1:0]  colour_i,
  output logic             strobe_o,
  output logic [PH_W-1:0]  phase_o
);
  logic             restart;
  logic [CNT_W-1:0] cnt;

  chroma_hs_qual #(.MIN_HS(MIN_HS)) u_qual (
    .clk_i, .rst_ni, .hsync_i, .restart_o(restart)
  );

  chroma_phase_cnt #(.SC_DIV(SC_DIV)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .cnt_o(cnt)
  );

  chroma_strobe_gen #(.SC_DIV(SC_DIV), .DAC_N(DAC_N), .PH_N(PH_N)) u_strb (
    .clk_i, .rst_ni, .cnt_i(cnt), .offset_i, .colour_i, .strobe_o, .phase_o
  );
endmodule

// File: rtl/chroma_phase_gen_chk.sv
module chroma_phase_gen_chk #(
  parameter int unsigned SC_DIV = 64,
  parameter int unsigned DAC_N  = 4,
  parameter int unsigned PH_N   = 16,
  localparam int unsigned CNT_W = $clog2(SC_DIV),
  localparam int unsigned PH_W  = $clog2(PH_N),
  localparam int unsigned GRID  = PH_N / DAC_N
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] offset_i,
  input logic [PH_W-1:0]  colour_i,
  input logic             strobe_o,
  input logic [PH_W-1:0]  phase_o,
  input logic             restart,
  input logic [CNT_W-1:0] cnt
);
  assert_restart_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (cnt == '0));

  assert_single_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !restart);

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  assert_strobe_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o && !$past(restart) && $stable(offset_i)) |=> !strobe_o);

  assert_phase_grid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> ((PH_W'(phase_o - $past(colour_i)) % GRID) == 0));
endmodule

bind chroma_phase_gen chroma_phase_gen_chk #(.SC_DIV(SC_DIV), .DAC_N(DAC_N), .PH_N(PH_N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .offset_i(offset_i), .colour_i(colour_i),
  .strobe_o(strobe_o), .phase_o(phase_o), .restart(restart), .cnt(cnt)
);

// File: tb/chroma_phase_gen_tb.sv
module chroma_phase_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_HS     = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hs = 1'b0;
  logic [5:0] off = '0;
  logic [3:0] col = '0;
  logic       strobe;
  logic [3:0] phase;

  int errors = 0, checks = 0;
  int j = 0, cd = -1, run = 0;
  bit done = 1'b0;
  string ctx = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_phase_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .offset_i(off),
    .colour_i(col), .strobe_o(strobe), .phase_o(phase)
  );

  function automatic int rel_of(int cnt, int o);
    return ((cnt - o) % 64 + 64) % 64;
  endfunction
  function automatic bit exp_strobe(int cnt, int o);
    return (rel_of(cnt, o) % 16) == 0;
  endfunction
  function automatic int exp_phase(int cnt, int o, int c);
    return ((rel_of(cnt, o) >> 2) + c) % 16;
  endfunction

  task automatic check_out();
    checks++;
    if (strobe !== exp_strobe(j, off)) begin
      errors++;
      $display("FAIL %s/R5 strobe_o=%0b expected=%0b (count %0d off %0d)",
               ctx, strobe, exp_strobe(j, off), j, off);
    end
    checks++;
    if (phase !== 4'(exp_phase(j, off, col))) begin
      errors++;
      $display("FAIL %s/R6 phase_o=%0d expected=%0d (count %0d off %0d col %0d)",
               ctx, phase, exp_phase(j, off, col), j, off, col);
    end
  endtask

  // one clock: outputs at this negedge reflect count j
  task automatic step();
    @(negedge clk);
    if (hs) run++; else run = 0;
    if (cd > 0) begin
      cd--;
      if (cd == 0) begin j = 0; cd = -1; end
    end
    check_out();
    j = (j + 1) % 64;
  endtask

  task automatic hold_high(int n);
    hs = 1'b1;
    repeat (n) step();
  endtask

  task automatic drive_low(int n);
    if (hs && run >= MIN_HS) cd = 4;  // R2: restart expected
    hs = 1'b0;
    repeat (n) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (strobe !== 1'b0 || phase !== 4'd0) begin
      errors++;
      $display("FAIL R1 reset strobe_o=%0b phase_o=%0d expected=0/0", strobe, phase);
    end
    rst_n = 1'b1;
    j = 0;
    ctx = "R1";
    step();
    // R4: free run and wrap
    ctx = "R4";
    repeat (70) step();
    // R2: run of exactly the minimum width restarts
    ctx = "R2";
    off = 6'd5;
    hold_high(MIN_HS);
    drive_low(40);
    // R3: one cycle short, and a single-cycle spike, do not restart
    ctx = "R3";
    hold_high(MIN_HS - 1);
    drive_low(30);
    hold_high(1);
    drive_low(20);
    // R7: offset extremes
    ctx = "R7";
    off = 6'd63;
    hold_high(MIN_HS + 3);
    drive_low(70);
    off = 6'd0;
    repeat (20) step();
    // R8: colour wrap
    ctx = "R8";
    col = 4'd15;
    repeat (70) step();
    // random lines
    ctx = "R5";
    for (int k = 0; k < 40; k++) begin
      off = 6'($urandom_range(0, 63));
      col = 4'($urandom_range(0, 15));
      hold_high(int'($urandom_range(1, 2 * MIN_HS)));
      drive_low(int'($urandom_range(10, 140)));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule